// File: doc/BRIEF.md
# Scaled-Index Effective Address Calculator

This unit turns an already decoded addressing-mode descriptor into a 32-bit memory address. The decoder supplies a 3-bit mode code, the contents of the base register, the contents and number of the index register, a 2-bit scale code and a displacement that the instruction carried as either one signed byte or a full signed word. The unit adds the parts that the mode selects and presents the sum one clock later, together with a flag that marks an illegal index or displacement choice.

The mode decides which of base, scaled index and displacement enter the sum. The scale is a left shift of the index by 0 to 3 places, so the index counts once, twice, four or eight times. A short displacement is sign-extended before the addition. Every sum wraps modulo 2^32. The stack pointer (register number 4) may never act as an index. The mode without a base register accepts only a full-word displacement. When either rule is broken, or a reserved mode code arrives, the flag rises. In the first two cases the address is still formed from the given operands, so the pipeline can carry the value into the fault report.

Top module: `ea_calc`

## Requirements
- R1: While rst_n is low, eff_addr is 0 and idx_fault is 0.
- R2: A result is captured on the rising clock edge at which calc_en is 1 and shows on the outputs from then on. When calc_en is 0, eff_addr and idx_fault keep their values whatever the other inputs do.
- R3: Mode code 0 (absolute): eff_addr equals all 32 bits of disp, whatever disp_long says, and idx_fault is 0.
- R4: Mode code 1 (register indirect): eff_addr equals base_val and idx_fault is 0.
- R5: Mode code 2 (base plus displacement): eff_addr = base_val + D. D is disp when disp_long is 1. When disp_long is 0, D is disp[7:0] sign-extended to 32 bits and disp[31:8] is ignored.
- R6: Mode code 3 (scaled index plus displacement, no base): eff_addr = idx_val * 2^scale + D. Scale codes 0, 1, 2 and 3 give factors 1, 2, 4 and 8, and only the index is scaled.
- R7: In mode code 3, disp_long = 0 raises idx_fault. The address is still formed with the sign-extended byte.
- R8: Mode code 4 (base plus scaled index): eff_addr = base_val + idx_val * 2^scale. disp plays no part.
- R9: Mode code 5 (base plus scaled index plus displacement): eff_addr = base_val + idx_val * 2^scale + D.
- R10: In modes 3, 4 and 5, idx_num = 4 (the stack pointer) raises idx_fault and eff_addr is still computed. In modes 0, 1 and 2, idx_num has no effect.
- R11: All sums, and the scaled index itself, wrap modulo 2^32.
- R12: Mode codes 6 and 7 are reserved. They give eff_addr = 0 and idx_fault = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| calc_en | input | 1 | Capture a new address on this edge |
| mode | input | 3 | Addressing-mode code (0 to 5 used, 6 and 7 reserved) |
| base_val | input | 32 | Base register contents |
| idx_val | input | 32 | Index register contents |
| idx_num | input | 3 | Number of the register used as index |
| scale | input | 2 | Index shift amount (factor 1, 2, 4 or 8) |
| disp | input | 32 | Displacement; only bits 7:0 count when short |
| disp_long | input | 1 | 1 = 32-bit displacement, 0 = 8-bit |
| eff_addr | output | 32 | Registered effective address |
| idx_fault | output | 1 | Registered illegal index, displacement or mode flag |

## Verification
The bench uses the default parameters: 32-bit addresses, 3-bit register numbers, an 8-bit short displacement and register 4 as the stack pointer. These settings let it sweep every mode code, every scale code, all eight index register numbers and both displacement sizes, each against three operand sets. One operand set has a negative short byte with junk in the upper displacement bits. Another forces carries out of bit 31. The sweep therefore reaches every fault cause, the sign-extension boundary and the wraparound. The bench also changes the inputs while the enable is low and confirms the outputs hold.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    AM_ABS       = 3'd0,
    AM_REG_IND   = 3'd1,
    AM_BASE_DISP = 3'd2,
    AM_IDX_DISP  = 3'd3,
    AM_BASE_IDX  = 3'd4,
    AM_FULL      = 3'd5,
    AM_RSV6      = 3'd6,
    AM_RSV7      = 3'd7
  } am_mode_e;

  typedef struct packed {
    logic use_base;
    logic use_index;
    logic use_disp;
    logic force_long;
    logic need_long;
    logic mode_ok;
  } am_sel_t;

endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
  import ea_pkg::*;
(
  input  logic [2:0] mode,
  output am_sel_t    sel
);

  am_mode_e mode_e;

  always_comb begin
    mode_e = am_mode_e'(mode);
    sel    = '0;
    unique case (mode_e)
      AM_ABS: begin
        sel.use_disp   = 1'b1;
        sel.force_long = 1'b1;
        sel.mode_ok    = 1'b1;
      end
      AM_REG_IND: begin
        sel.use_base = 1'b1;
        sel.mode_ok  = 1'b1;
      end
      AM_BASE_DISP: begin
        sel.use_base = 1'b1;
        sel.use_disp = 1'b1;
        sel.mode_ok  = 1'b1;
      end
      AM_IDX_DISP: begin
        sel.use_index = 1'b1;
        sel.use_disp  = 1'b1;
        sel.need_long = 1'b1;
        sel.mode_ok   = 1'b1;
      end
      AM_BASE_IDX: begin
        sel.use_base  = 1'b1;
        sel.use_index = 1'b1;
        sel.mode_ok   = 1'b1;
      end
      AM_FULL: begin
        sel.use_base  = 1'b1;
        sel.use_index = 1'b1;
        sel.use_disp  = 1'b1;
        sel.mode_ok   = 1'b1;
      end
      default: begin
        sel = '0;
      end
    endcase
  end

endmodule

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 8
) (
  input  logic [ADDR_W-1:0] disp,
  input  logic              wide,
  output logic [ADDR_W-1:0] disp_x
);

  localparam int PAD_W = ADDR_W - SHORT_W;

  logic [SHORT_W-1:0] short_part;
  logic [ADDR_W-1:0]  short_ext;

  assign short_part = disp[SHORT_W-1:0];
  assign short_ext  = {{PAD_W{short_part[SHORT_W-1]}}, short_part};

  always_comb begin
    if (wide) disp_x = disp;
    else      disp_x = short_ext;
  end

endmodule

// File: rtl/ea_idx_scale.sv
module ea_idx_scale #(
  parameter int ADDR_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic [ADDR_W-1:0]  idx_val,
  input  logic [SCALE_W-1:0] scale,
  output logic [ADDR_W-1:0]  idx_scaled
);

  localparam int N_SHIFT = 1 << SCALE_W;

  logic [ADDR_W-1:0] cand [N_SHIFT];

  for (genvar s = 0; s < N_SHIFT; s++) begin : g_shift
    if (s == 0) begin : g_zero
      assign cand[s] = idx_val;
    end else begin : g_move
      assign cand[s] = {idx_val[ADDR_W-1-s:0], {s{1'b0}}};
    end
  end

  assign idx_scaled = cand[scale];

endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REG_NUM_W = 3,
  parameter int SHORT_W   = 8,
  parameter int SCALE_W   = 2,
  parameter int SP_NUM    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 calc_en,
  input  logic [2:0]           mode,
  input  logic [ADDR_W-1:0]    base_val,
  input  logic [ADDR_W-1:0]    idx_val,
  input  logic [REG_NUM_W-1:0] idx_num,
  input  logic [SCALE_W-1:0]   scale,
  input  logic [ADDR_W-1:0]    disp,
  input  logic                 disp_long,
  output logic [ADDR_W-1:0]    eff_addr,
  output logic                 idx_fault
);

  localparam logic [REG_NUM_W-1:0] SP_CODE = REG_NUM_W'(SP_NUM);

  am_sel_t           sel;
  logic [ADDR_W-1:0] disp_x;
  logic [ADDR_W-1:0] idx_scaled;
  logic [ADDR_W-1:0] term_base;
  logic [ADDR_W-1:0] term_idx;
  logic [ADDR_W-1:0] term_disp;
  logic              sp_hit;
  logic              short_bad;
  logic [ADDR_W-1:0] addr_d;
  logic              fault_d;
  logic [ADDR_W-1:0] addr_q;
  logic              fault_q;

  ea_mode_dec u_dec (
    .mode (mode),
    .sel  (sel)
  );

  ea_disp_ext #(
    .ADDR_W  (ADDR_W),
    .SHORT_W (SHORT_W)
  ) u_disp (
    .disp   (disp),
    .wide   (disp_long | sel.force_long),
    .disp_x (disp_x)
  );

  ea_idx_scale #(
    .ADDR_W  (ADDR_W),
    .SCALE_W (SCALE_W)
  ) u_scale (
    .idx_val    (idx_val),
    .scale      (scale),
    .idx_scaled (idx_scaled)
  );

  // operand gating per mode
  assign term_base = sel.use_base  ? base_val   : '0;
  assign term_idx  = sel.use_index ? idx_scaled : '0;
  assign term_disp = sel.use_disp  ? disp_x     : '0;

  assign sp_hit    = sel.use_index & (idx_num == SP_CODE);
  assign short_bad = sel.need_long & ~disp_long;

  // next-state
  always_comb begin
    addr_d  = addr_q;
    fault_d = fault_q;
    if (calc_en) begin
      if (sel.mode_ok) addr_d = term_base + term_idx + term_disp;
      else             addr_d = '0;
      fault_d = ~sel.mode_ok | sp_hit | short_bad;
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      fault_q <= fault_d;
    end
  end

  assign eff_addr  = addr_q;
  assign idx_fault = fault_q;

endmodule

// File: rtl/ea_calc_chk.sv
module ea_calc_chk #(
  parameter int ADDR_W    = 32,
  parameter int REG_NUM_W = 3,
  parameter int SP_NUM    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 calc_en,
  input logic [2:0]           mode,
  input logic [ADDR_W-1:0]    base_val,
  input logic [REG_NUM_W-1:0] idx_num,
  input logic [ADDR_W-1:0]    disp,
  input logic                 disp_long,
  input logic [ADDR_W-1:0]    eff_addr,
  input logic                 idx_fault
);

  logic indexed;
  assign indexed = (mode == 3'd3) || (mode == 3'd4) || (mode == 3'd5);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !calc_en |=> ($stable(eff_addr) && $stable(idx_fault)));

  assert_absolute_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_en && mode == 3'd0) |=> (eff_addr == $past(disp) && !idx_fault));

  assert_reg_ind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_en && mode == 3'd1) |=> (eff_addr == $past(base_val) && !idx_fault));

  assert_short_disp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_en && mode == 3'd3 && !disp_long) |=> idx_fault);

  assert_sp_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_en && indexed && idx_num == REG_NUM_W'(SP_NUM)) |=> idx_fault);

  assert_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_en && mode[2:1] == 2'b11) |=> (eff_addr == '0 && idx_fault));

endmodule

bind ea_calc ea_calc_chk #(
  .ADDR_W    (ADDR_W),
  .REG_NUM_W (REG_NUM_W),
  .SP_NUM    (SP_NUM)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .calc_en   (calc_en),
  .mode      (mode),
  .base_val  (base_val),
  .idx_num   (idx_num),
  .disp      (disp),
  .disp_long (disp_long),
  .eff_addr  (eff_addr),
  .idx_fault (idx_fault)
);

// File: tb/test_ea_calc.sv
module test_ea_calc;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        calc_en;
  logic [2:0]  mode;
  logic [31:0] base_val;
  logic [31:0] idx_val;
  logic [2:0]  idx_num;
  logic [1:0]  scale;
  logic [31:0] disp;
  logic        disp_long;
  logic [31:0] eff_addr;
  logic        idx_fault;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_calc i_ea_calc (
    .clk       (clk),
    .rst_n     (rst_n),
    .calc_en   (calc_en),
    .mode      (mode),
    .base_val  (base_val),
    .idx_val   (idx_val),
    .idx_num   (idx_num),
    .scale     (scale),
    .disp      (disp),
    .disp_long (disp_long),
    .eff_addr  (eff_addr),
    .idx_fault (idx_fault)
  );

  function automatic logic [31:0] ext_disp(input logic [31:0] d, input logic lng);
    longint v;
    if (lng) return d;
    v = longint'(d % 256);
    if (v >= 128) v = v - 256;
    return 32'(v);
  endfunction

  function automatic logic [31:0] model_addr(input int m, input logic [31:0] b,
      input logic [31:0] x, input int sc, input logic [31:0] d, input logic lng);
    longint xs;
    xs = longint'(x) * (longint'(1) << sc);
    case (m)
      0: return d;
      1: return b;
      2: return 32'(longint'(b) + longint'(ext_disp(d, lng)));
      3: return 32'(xs + longint'(ext_disp(d, lng)));
      4: return 32'(longint'(b) + xs);
      5: return 32'(longint'(b) + xs + longint'(ext_disp(d, lng)));
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic model_fault(input int m, input int n, input logic lng);
    if (m > 5) return 1'b1;
    if (m >= 3 && n == 4) return 1'b1;
    if (m == 3 && !lng) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string addr_tag(input int m, input int set);
    if (set == 2 && m >= 2 && m <= 5) return "R11";
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R8";
      5: return "R9";
      default: return "R12";
    endcase
  endfunction

  function automatic string fault_tag(input int m, input int n, input logic lng);
    if (m > 5) return "R12";
    if (m == 3 && !lng) return "R7";
    return "R10";
  endfunction

  task automatic check_pair(input string tag_a, input logic [31:0] exp_a,
                            input string tag_f, input logic exp_f);
    checks++;
    if (eff_addr !== exp_a) begin
      errors++;
      $display("FAIL %s eff_addr actual %h expected %h", tag_a, eff_addr, exp_a);
    end
    checks++;
    if (idx_fault !== exp_f) begin
      errors++;
      $display("FAIL %s idx_fault actual %b expected %b", tag_f, idx_fault, exp_f);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] bs [3];
    logic [31:0] xs [3];
    logic [31:0] ds [3];
    logic [31:0] last_a;
    logic        last_f;
    bs[0] = 32'h1000_0000; xs[0] = 32'h0000_0025; ds[0] = 32'h0000_0034;
    bs[1] = 32'h0000_2000; xs[1] = 32'h1234_5678; ds[1] = 32'hABCD_EF90;
    bs[2] = 32'hFFFF_FFF0; xs[2] = 32'h8000_0001; ds[2] = 32'h7FFF_FF7F;

    rst_n = 1'b0; calc_en = 1'b1; mode = 3'd5; base_val = 32'hDEAD_BEEF;
    idx_val = 32'h1; idx_num = 3'd4; scale = 2'd3; disp = 32'h55; disp_long = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state despite active inputs
    check_pair("R1", 32'd0, "R1", 1'b0);
    rst_n = 1'b1;

    for (int set = 0; set < 3; set++) begin
      for (int m = 0; m < 8; m++) begin
        for (int sc = 0; sc < 4; sc++) begin
          for (int n = 0; n < 8; n++) begin
            for (int l = 0; l < 2; l++) begin
              calc_en   = 1'b1;
              mode      = 3'(m);
              base_val  = bs[set] + 32'(n);
              idx_val   = xs[set] + 32'(sc);
              idx_num   = 3'(n);
              scale     = 2'(sc);
              disp      = ds[set];
              disp_long = l[0];
              @(negedge clk);
              check_pair(addr_tag(m, set),
                         model_addr(m, bs[set] + 32'(n), xs[set] + 32'(sc), sc, ds[set], l[0]),
                         fault_tag(m, n, l[0]),
                         model_fault(m, n, l[0]));
            end
          end
        end
      end
    end

    // R2: enable low, inputs change, outputs hold
    calc_en = 1'b1; mode = 3'd5; base_val = 32'h100; idx_val = 32'h10;
    idx_num = 3'd1; scale = 2'd2; disp = 32'h8; disp_long = 1'b1;
    @(negedge clk);
    last_a = 32'h148; last_f = 1'b0;
    check_pair("R2", last_a, "R2", last_f);
    calc_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      mode = 3'(k); idx_num = 3'd4; base_val = 32'(k * 977); disp_long = 1'b0;
      @(negedge clk);
      check_pair("R2", last_a, "R2", last_f);
    end
    // R2: capture resumes with one-cycle latency
    calc_en = 1'b1; mode = 3'd1; base_val = 32'hCAFE_0000;
    @(negedge clk);
    check_pair("R2", 32'hCAFE_0000, "R2", 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule